// File: doc/BRIEF.md
# Typed Management Register Bit Bank

A bank of management register bits in which each bit position is given its own access type at build time. The types are read-only, write-only, read/write, self-clearing, latch-on-low, latch-on-high and latch-on-change. Live status lines from the datapath enter on one side. On the other side the bank takes a read strobe, a write strobe with data, and per-bit completion pulses for the self-clearing bits. It returns the value that a register read would see, and the configuration value held by the writable bits. It also drives one interrupt line, which goes high when any enabled latch-on-change bit has an event pending.

A sticky bit keeps the first event of interest visible until software reads the register. The read then refreshes every latching bit from its live input and clears the pending change flags. An event that arrives in the same cycle as the read is kept: it is re-latched and re-armed, so no event is lost. The access type of each bit is a 3-bit code in a build parameter. The code values are 0 read-only, 1 write-only, 2 read/write, 3 self-clearing, 4 latch-on-low, 5 latch-on-high and 6 latch-on-change. By default, bit i takes the code i mod 7.

Top module: `mgmt_status_bank`

## Requirements
- R1: After reset, all stored bits are 0 except latch-on-low bits, which are 1. No change flag is pending, the interrupt line is 0, and the previous live sample is taken as 0.
- R2: A read-only bit shows its live input on the read value in the same cycle, and writes do not change it.
- R3: A write-only bit always reads as 0. A write stores its data bit, which appears on the configuration output after the clock edge.
- R4: A read/write bit loads its data bit on a write. It shows that bit on both the read value and the configuration output until the next write.
- R5: A self-clearing bit loads its data bit on a write. It returns to 0 on the edge after its completion input is high with no write. A write in the same cycle as a completion takes priority.
- R6: A latch-on-low bit falls to 0 on the edge where its live input is low. It then stays 0 while no read occurs, even if the input returns high.
- R7: A latch-on-high bit rises to 1 on the edge where its live input is high. It then stays 1 while no read occurs.
- R8: A latch-on-change bit that sees its live input differ from the previous cycle's sample, with no flag pending, captures the new live value and sets its pending flag. Later changes do not alter the captured value while the flag is pending.
- R9: A read clears the pending flag of every latch-on-change bit whose input did not change in that cycle. If the input did change in the read cycle, the flag stays set.
- R10: The interrupt line is 1 exactly when some latch-on-change bit has its pending flag set and its enable bit set.
- R11: The read value during a read cycle is the latched value from before the edge. On that edge every latching bit reloads its current live input.
- R12: Writes have no effect on read-only, latch-on-low, latch-on-high or latch-on-change bits. Their read value and the configuration output stay as they would be without the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_i | input | WIDTH | Live status lines from the datapath |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | WIDTH | Write data |
| done_i | input | WIDTH | Per-bit completion for self-clearing bits |
| irq_en_i | input | WIDTH | Per-bit interrupt enable |
| rdata_o | output | WIDTH | Value a register read returns |
| cfg_o | output | WIDTH | Stored value of writable bits, 0 elsewhere |
| irq_o | output | 1 | Interrupt, OR of enabled pending flags |

## Verification
The bank is first driven with directed patterns. A single low pulse followed by a steady high tells a latch from a pass-through. A read whose input is steady is set against a read whose input moves, which shows clear-on-read apart from re-arm. A write of all ones with all lines low shows which bits are writable. Write-and-completion collisions expose the priority of self-clearing bits. Random traffic then mixes the strobes, live values and enable masks, and every clock is compared bit by bit with a behavioural model, so each type is separated by how it responds to the same stimulus.

// File: rtl/mgmt_bit_pkg.sv
package mgmt_bit_pkg;

  localparam int MAX_BITS = 32;

  typedef enum logic [2:0] {
    BK_RO = 3'd0,
    BK_WO = 3'd1,
    BK_RW = 3'd2,
    BK_SC = 3'd3,
    BK_LL = 3'd4,
    BK_LH = 3'd5,
    BK_LT = 3'd6
  } bit_kind_e;

  // Default type map: bit i gets code i mod 7.
  function automatic logic [3*MAX_BITS-1:0] cyclic_map();
    logic [3*MAX_BITS-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_BITS; i++) m[3*i +: 3] = 3'(i % 7);
    return m;
  endfunction

  // Live line differs from its previous sample.
  function automatic logic moved(input logic now_v, input logic prev_v);
    return now_v ^ prev_v;
  endfunction

endpackage

// File: rtl/mgmt_bit_cell.sv
module mgmt_bit_cell
  import mgmt_bit_pkg::*;
#(
  parameter bit_kind_e KIND = BK_RW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wd_i,
  input  logic done_i,
  output logic rd_o,
  output logic cfg_o,
  output logic pend_o
);

  logic q;
  logic pend;
  logic live_d;
  logic chg;

  assign chg = moved(live_i, live_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= (KIND == BK_LL);
      pend   <= 1'b0;
      live_d <= 1'b0;
    end else begin
      live_d <= live_i;
      case (KIND)
        BK_WO, BK_RW: if (wr_i) q <= wd_i;
        BK_SC: begin
          if (wr_i)        q <= wd_i;
          else if (done_i) q <= 1'b0;
        end
        BK_LL: q <= rd_i ? live_i : (q & live_i);
        BK_LH: q <= rd_i ? live_i : (q | live_i);
        BK_LT: begin
          if (rd_i) begin
            q    <= live_i;
            pend <= chg;
          end else if (chg && !pend) begin
            q    <= live_i;
            pend <= 1'b1;
          end
        end
        default: q <= q;
      endcase
    end
  end

  always_comb begin
    case (KIND)
      BK_RO:   rd_o = live_i;
      BK_WO:   rd_o = 1'b0;
      default: rd_o = q;
    endcase
  end

  assign cfg_o  = (KIND == BK_WO || KIND == BK_RW || KIND == BK_SC) ? q : 1'b0;
  assign pend_o = pend;

  assert_sc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == BK_SC) && !wr_i && done_i |=> !cfg_o);

  assert_ll_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == BK_LL) && !rd_i && !live_i |=> !rd_o);

  assert_lh_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == BK_LH) && !rd_i && live_i |=> rd_o);

  assert_lt_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == BK_LT) && chg |=> pend_o);

  assert_lt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == BK_LT) && rd_i && !chg |=> !pend_o);

endmodule

// File: rtl/mgmt_irq_merge.sv
module mgmt_irq_merge #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] pend_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             irq_o
);

  function automatic logic any_armed(input logic [WIDTH-1:0] p, input logic [WIDTH-1:0] e);
    return |(p & e);
  endfunction

  assign irq_o = any_armed(pend_i, en_i);

endmodule

// File: rtl/mgmt_status_bank.sv
module mgmt_status_bank
  import mgmt_bit_pkg::*;
#(
  parameter int                    WIDTH    = 16,
  parameter logic [3*MAX_BITS-1:0] KIND_MAP = cyclic_map()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] live_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] done_i,
  input  logic [WIDTH-1:0] irq_en_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] cfg_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] pend_w;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    localparam bit_kind_e K = bit_kind_e'(KIND_MAP[3*g +: 3]);
    mgmt_bit_cell #(.KIND(K)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .live_i (live_i[g]),
      .rd_i   (rd_i),
      .wr_i   (wr_i),
      .wd_i   (wdata_i[g]),
      .done_i (done_i[g]),
      .rd_o   (rdata_o[g]),
      .cfg_o  (cfg_o[g]),
      .pend_o (pend_w[g])
    );
  end

  mgmt_irq_merge #(.WIDTH(WIDTH)) u_irq (
    .pend_i (pend_w),
    .en_i   (irq_en_i),
    .irq_o  (irq_o)
  );

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_w & irq_en_i) == '0) |-> !irq_o);

  assert_irq_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (pend_w != '0));

endmodule

// File: tb/mgmt_status_bank_bench.sv
`timescale 1ns/1ps
module mgmt_status_bank_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] live = '0, wdata = '0, done = '0, en = '0;
  logic         rd = 1'b0, wr = 1'b0;
  logic [W-1:0] rdata, cfg;
  logic         irq;

  int checks = 0;
  int errors = 0;

  // Behavioural model state
  int m_q[W];
  int m_p[W];
  int m_ld[W];

  always #10 clk = ~clk;

  mgmt_status_bank u_mgmt_status_bank (
    .clk(clk), .rst_n(rst_n), .live_i(live), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .done_i(done), .irq_en_i(en),
    .rdata_o(rdata), .cfg_o(cfg), .irq_o(irq)
  );

  function automatic int kind(int i);
    return i % 7;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < W; i++) begin
      if (!rst_n) begin
        m_q[i] = (kind(i) == 4) ? 1 : 0;
        m_p[i] = 0;
        m_ld[i] = 0;
      end else begin
        int l, mv;
        l  = live[i];
        mv = (l != m_ld[i]) ? 1 : 0;
        case (kind(i))
          1, 2: if (wr) m_q[i] = wdata[i];
          3: if (wr) m_q[i] = wdata[i]; else if (done[i]) m_q[i] = 0;
          4: if (rd) m_q[i] = l; else if (l == 0) m_q[i] = 0;
          5: if (rd) m_q[i] = l; else if (l == 1) m_q[i] = 1;
          6: begin
            if (rd) begin m_q[i] = l; m_p[i] = mv; end
            else if (mv == 1 && m_p[i] == 0) begin m_q[i] = l; m_p[i] = 1; end
          end
          default: ;
        endcase
        m_ld[i] = l;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare_all();
    int exp_irq;
    exp_irq = 0;
    for (int i = 0; i < W; i++) begin
      int er, ec, k;
      k  = kind(i);
      er = (k == 0) ? int'(live[i]) : (k == 1) ? 0 : m_q[i];
      ec = (k >= 1 && k <= 3) ? m_q[i] : 0;
      chk(int'(rdata[i]) == er, tag_of(k), $sformatf("rdata[%0d]", i), int'(rdata[i]), er);
      chk(int'(cfg[i]) == ec, (k == 0 || k >= 4) ? "R12" : tag_of(k),
          $sformatf("cfg[%0d]", i), int'(cfg[i]), ec);
      if (m_p[i] != 0 && en[i]) exp_irq = 1;
    end
    chk(int'(irq) == exp_irq, "R10", "irq", int'(irq), exp_irq);
  endtask

  // Apply inputs for one cycle, compare mid low phase, advance to next negedge.
  task automatic cyc(input logic [W-1:0] l, input logic r, input logic w,
                     input logic [W-1:0] d, input logic [W-1:0] dn);
    live = l; rd = r; wr = w; wdata = d; done = dn;
    #5;
    compare_all();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ones;
    ones = '1;
    en = ones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1: reset state, latch-on-low bits (4, 11) at 1
    chk(rdata == 16'h0810, "R1", "rdata after reset", int'(rdata), 16'h0810);
    chk(cfg == '0, "R1", "cfg after reset", int'(cfg), 0);
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
    @(negedge clk);

    cyc(ones, 0, 0, '0, '0);
    cyc('0, 0, 0, '0, '0);
    cyc('0, 0, 1, ones, '0);
    cyc('0, 0, 0, '0, ones);
    cyc('0, 0, 1, ones, ones);   // R5 write beats completion
    cyc('0, 0, 0, '0, '0);
    cyc(ones, 1, 0, '0, '0);

    // R11: latched low stays visible in the read cycle, reloads after
    cyc(ones, 1, 0, '0, '0);
    cyc('0, 0, 0, '0, '0);
    live = ones; rd = 0; #5;
    chk(rdata[4] == 1'b0, "R6", "LL bit held low", int'(rdata[4]), 0);
    compare_all();
    @(negedge clk);
    live = ones; rd = 1; #5;
    chk(rdata[4] == 1'b0, "R11", "LL bit in read cycle", int'(rdata[4]), 0);
    compare_all();
    @(negedge clk);
    live = ones; rd = 0; #5;
    chk(rdata[4] == 1'b1, "R11", "LL bit after read", int'(rdata[4]), 1);
    // R9: read with steady input cleared the flags
    chk(irq == 1'b0, "R9", "irq after steady read", int'(irq), 0);
    compare_all();
    @(negedge clk);
    // R9: change in the read cycle re-arms
    cyc('0, 1, 0, '0, '0);
    live = '0; rd = 0; #5;
    chk(irq == 1'b1, "R9", "irq re-armed by read-cycle change", int'(irq), 1);
    compare_all();
    @(negedge clk);

    // R12: all-ones write with lines low leaves RO and latching bits alone
    cyc('0, 1, 0, '0, '0);
    cyc('0, 0, 1, ones, '0);
    live = '0; rd = 0; wr = 0; #5;
    chk(rdata[0] == 1'b0, "R12", "RO bit after write", int'(rdata[0]), 0);
    chk(rdata[5] == 1'b0, "R12", "LH bit after write", int'(rdata[5]), 0);
    chk(rdata[1] == 1'b0, "R3", "WO bit reads 0", int'(rdata[1]), 0);
    chk(cfg[1] == 1'b1, "R3", "WO bit stored", int'(cfg[1]), 1);
    compare_all();
    @(negedge clk);

    // Interrupt mask patterns
    en = 16'h0040;
    cyc(ones, 0, 0, '0, '0);
    en = 16'h2000;
    cyc(ones, 0, 0, '0, '0);
    en = '0;
    cyc('0, 0, 0, '0, '0);
    en = ones;
    cyc('0, 1, 0, '0, '0);

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      en = W'($urandom);
      cyc(W'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
          W'($urandom), W'($urandom) & W'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule